// File: doc/BRIEF.md
# Masked Scalar Binary64 Multiply Unit

This unit multiplies the low 64-bit lanes of two vector operands as IEEE 754 binary64 numbers and assembles a complete destination register around the product. Three encoding forms are accepted. The destructive two-operand form keeps every destination bit above the low lane. The three-operand form copies bits 127:64 from the first source and clears everything above bit 127. The masked three-operand form does the same and also gates the low lane with a one-bit writemask that can either merge or zero. The rounding direction normally comes from a control-register field. In the masked form, when a static-rounding enable is set and the second operand came from a register, an instruction-supplied rounding field takes over.

The arithmetic is one combinational stage followed by an output register. Operands that arrive with `in_valid` produce a registered result and a one-cycle `out_valid` pulse on the next clock. Five exception flags come with each result: invalid, denormal operand, overflow, underflow and inexact. They are meant to be ORed into a status register by the consumer. Flush-to-zero, denormals-are-zero, trapping, decode and operand fetch are handled elsewhere. The top holds a two-state output sequencer. In `ST_IDLE` it moves to `ST_SHOW` when `in_valid` is high and otherwise stays. In `ST_SHOW` it returns to `ST_IDLE` when `in_valid` is low and stays in `ST_SHOW` on back-to-back inputs. `out_valid` is high exactly in `ST_SHOW`.

Top module: `scalar_dmul_unit`

## Requirements
- R1: Destination bits 63:0 hold the binary64 product of `src_a[63:0]` and `src_b[63:0]`, rounded per the 2-bit mode code: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R2: The mode code `rc_static` is used only when `form` is masked (code 10 or 11), `rc_static_en` is 1 and `b_is_reg` is 1. In every other case `rc_csr` is used.
- R3: With `form` = 00 (destructive), `dst_new[VLEN-1:64]` equals `dst_old[VLEN-1:64]`.
- R4: With `form` = 01, 10 or 11, `dst_new[127:64]` equals `src_a[127:64]` and `dst_new[VLEN-1:128]` is zero.
- R5: In the masked forms, if `mask_en` is 1 and `mask_bit` is 0, the low lane takes the value 0 when `zero_mode` is 1 and keeps `dst_old[63:0]` when it is 0. All five flags are then 0. In every other case the low lane receives the product.
- R6: A NaN operand yields the quiet version of that NaN (bit 51 set, other payload kept). If both operands are NaN, `src_a` wins. Invalid is raised if either operand is a signaling NaN (bit 51 clear).
- R7: Infinity times zero, in either order, gives 0xFFF8_0000_0000_0000 and raises invalid.
- R8: The sign of every non-NaN result is the XOR of the operand signs, including zero and infinity results.
- R9: On overflow the result is infinity under nearest-even, largest finite under toward-zero, and infinity only in the rounding direction under the two directed modes. Overflow and inexact are both raised.
- R10: Underflow is raised when the exact product is below 2^-1022 in magnitude (tininess before rounding) and the rounded result is inexact. An exactly representable subnormal result raises neither underflow nor inexact.
- R11: Denormal is raised when either operand is subnormal and neither operand is a NaN.
- R12: Reset clears `out_valid`, `dst_new` and `exc_flags`. `out_valid` is 1 exactly one cycle after an `in_valid` cycle, and outputs hold their values while `in_valid` is low.
- R13: `exc_flags` bit 4 is invalid, bit 3 denormal, bit 2 overflow, bit 1 underflow and bit 0 inexact. Inexact is set whenever the delivered finite result differs from the exact product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands present this cycle |
| form | input | 2 | Encoding form: 00 destructive, 01 three-operand, 10/11 masked three-operand |
| src_a | input | 128 | First source, low 128 bits |
| src_b | input | 64 | Second source low lane (register or memory quadword) |
| dst_old | input | VLEN | Current destination register value |
| mask_en | input | 1 | A writemask is in use (masked form only) |
| mask_bit | input | 1 | Writemask bit 0 |
| zero_mode | input | 1 | 1 zeroing masking, 0 merging masking |
| rc_static_en | input | 1 | Static rounding override requested |
| b_is_reg | input | 1 | Second source came from a register |
| rc_static | input | 2 | Instruction-supplied rounding code |
| rc_csr | input | 2 | Control-register rounding code |
| out_valid | output | 1 | Result registered this cycle |
| dst_new | output | VLEN | New destination register value |
| exc_flags | output | 5 | {invalid, denormal, overflow, underflow, inexact} |

## Verification
The hardest condition to reach from the ports is a product that lands below the normal range. There, the subnormal shift, the sticky bits it discards and the tininess test all combine, and random normal operands almost never get there. Directed operands built around the smallest normal and smallest subnormal values force exact subnormals, a halfway tie that rounds to zero and a tie that rounds up under the upward mode. A suppressed-flag case places overflowing operands behind a cleared writemask, so the flags would show if the masking failed. The random stream keeps exponents in a band whose products stay normal and crosses every form, mask setting and rounding source. The bench checks it against a real-valued product for nearest-even and against an integer-rounding function for the directed modes.

// File: rtl/dmul_pkg.sv
`timescale 1ns/1ps
package dmul_pkg;

    localparam int LANE_W   = 64;
    localparam int EXP_W    = 11;
    localparam int FRAC_W   = 52;
    localparam int MANT_W   = FRAC_W + 1;
    localparam int PROD_W   = 2 * MANT_W;
    localparam int LZ_W     = $clog2(PROD_W);
    localparam int EW_W     = EXP_W + 3;
    localparam int EXP_MAX  = (1 << EXP_W) - 1;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        FORM_DESTRUCT  = 2'b00,
        FORM_THREE_OP  = 2'b01,
        FORM_MASKED    = 2'b10,
        FORM_MASKED_B  = 2'b11
    } form_e;

    typedef struct packed {
        logic inv;
        logic den;
        logic ovf;
        logic unf;
        logic inx;
    } exc_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } ostate_e;

    function automatic logic form_is_masked(input form_e f);
        return (f == FORM_MASKED) || (f == FORM_MASKED_B);
    endfunction

endpackage

// File: rtl/dmul_rsel.sv
`timescale 1ns/1ps
module dmul_rsel
    import dmul_pkg::*;
(
    input  form_e      form,
    input  logic       rc_static_en,
    input  logic       b_is_reg,
    input  logic [1:0] rc_static,
    input  logic [1:0] rc_csr,
    output rmode_e     rmode
);

    logic use_static;

    always_comb begin
        use_static = form_is_masked(form) && rc_static_en && b_is_reg;
        rmode      = use_static ? rmode_e'(rc_static) : rmode_e'(rc_csr);
    end

endmodule

// File: rtl/dmul_core.sv
`timescale 1ns/1ps
module dmul_core
    import dmul_pkg::*;
(
    input  logic [LANE_W-1:0] opa,
    input  logic [LANE_W-1:0] opb,
    input  rmode_e            rmode,
    output logic [LANE_W-1:0] res,
    output exc_t              flags
);

    localparam int SH_CAP = PROD_W + 1;

    logic [LANE_W-1:0] ops [2];
    logic [1:0]        is_nan, is_snan, is_inf, is_zero, is_sub, sgn;
    logic [EXP_W-1:0]  eff_exp [2];
    logic [MANT_W-1:0] mant [2];

    assign ops[0] = opa;
    assign ops[1] = opb;

    genvar gi;
    for (gi = 0; gi < 2; gi++) begin : g_cls
        logic [EXP_W-1:0]  e;
        logic [FRAC_W-1:0] f;
        assign e             = ops[gi][LANE_W-2:FRAC_W];
        assign f             = ops[gi][FRAC_W-1:0];
        assign sgn[gi]       = ops[gi][LANE_W-1];
        assign is_nan[gi]    = (&e) & (|f);
        assign is_snan[gi]   = (&e) & (|f) & ~f[FRAC_W-1];
        assign is_inf[gi]    = (&e) & ~(|f);
        assign is_zero[gi]   = ~(|e) & ~(|f);
        assign is_sub[gi]    = ~(|e) & (|f);
        assign eff_exp[gi]   = (|e) ? e : EXP_W'(1);
        assign mant[gi]      = {|e, f};
    end

    logic                    rsign;
    logic [PROD_W-1:0]       prod;
    logic [LZ_W-1:0]         lz;
    logic [PROD_W-1:0]       norm;
    logic signed [EW_W-1:0]  exp_n;
    logic                    tiny;
    logic [EW_W-1:0]         sh_raw;
    logic [LZ_W:0]           sh;
    logic [PROD_W-1:0]       shifted;
    logic                    lost;
    logic [MANT_W-1:0]       kept;
    logic                    guard, sticky, inc;
    logic [MANT_W:0]         m_rnd;
    logic signed [EW_W-1:0]  fin_exp;
    logic                    inexact, huge, to_inf;

    assign rsign = sgn[0] ^ sgn[1];
    assign prod  = mant[0] * mant[1];

    always_comb begin
        lz = '0;
        for (int i = 0; i < PROD_W; i++) begin
            if (prod[i]) lz = LZ_W'(PROD_W - 1 - i);
        end
    end

    always_comb begin
        norm    = prod << lz;
        exp_n   = $signed({3'b000, eff_exp[0]}) + $signed({3'b000, eff_exp[1]})
                - EW_W'(1022) - $signed({{(EW_W-LZ_W){1'b0}}, lz});
        tiny    = exp_n < $signed(EW_W'(1));
        sh_raw  = tiny ? EW_W'($signed(EW_W'(1)) - exp_n) : '0;
        sh      = (sh_raw > EW_W'(SH_CAP)) ? (LZ_W+1)'(SH_CAP) : sh_raw[LZ_W:0];
        shifted = norm >> sh;
        lost    = tiny & (|(norm & ~({PROD_W{1'b1}} << sh)));
        kept    = shifted[PROD_W-1 -: MANT_W];
        guard   = shifted[PROD_W-1-MANT_W];
        sticky  = (|shifted[PROD_W-2-MANT_W:0]) | lost;
        unique case (rmode)
            RM_NEAR: inc = guard & (sticky | kept[0]);
            RM_DOWN: inc = (guard | sticky) & rsign;
            RM_UP:   inc = (guard | sticky) & ~rsign;
            RM_ZERO: inc = 1'b0;
        endcase
        m_rnd   = {1'b0, kept} + (MANT_W+1)'(inc);
        fin_exp = tiny ? $signed({{(EW_W-1){1'b0}}, m_rnd[MANT_W-1]})
                       : exp_n + $signed({{(EW_W-1){1'b0}}, m_rnd[MANT_W]});
        inexact = guard | sticky;
        huge    = !tiny && (fin_exp >= $signed(EW_W'(EXP_MAX)));
        to_inf  = (rmode == RM_NEAR) || (rmode == RM_DOWN && rsign)
               || (rmode == RM_UP && !rsign);
    end

    always_comb begin
        flags     = '0;
        flags.den = (|is_sub) & ~(|is_nan);
        if (|is_nan) begin
            flags.inv = |is_snan;
            if (is_nan[0]) res = {ops[0][LANE_W-1:FRAC_W], 1'b1, ops[0][FRAC_W-2:0]};
            else           res = {ops[1][LANE_W-1:FRAC_W], 1'b1, ops[1][FRAC_W-2:0]};
        end else if ((is_inf[0] & is_zero[1]) | (is_inf[1] & is_zero[0])) begin
            flags.inv = 1'b1;
            res       = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
        end else if (|is_inf) begin
            res       = {rsign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (|is_zero) begin
            res       = {rsign, {(LANE_W-1){1'b0}}};
        end else if (huge) begin
            flags.ovf = 1'b1;
            flags.inx = 1'b1;
            res       = to_inf ? {rsign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                               : {rsign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
        end else begin
            flags.inx = inexact;
            flags.unf = tiny & inexact;
            res       = {rsign, fin_exp[EXP_W-1:0], m_rnd[FRAC_W-1:0]};
        end
    end

endmodule

// File: rtl/dmul_lane_build.sv
`timescale 1ns/1ps
module dmul_lane_build
    import dmul_pkg::*;
#(
    parameter int VLEN = 512
) (
    input  form_e              form,
    input  logic               mask_en,
    input  logic               mask_bit,
    input  logic               zero_mode,
    input  logic [LANE_W-1:0]  a_hi,
    input  logic [VLEN-1:0]    dst_old,
    input  logic [LANE_W-1:0]  prod,
    input  exc_t               flags_in,
    output logic [VLEN-1:0]    dst_out,
    output exc_t               flags_out
);

    localparam int KEEP_W = VLEN - LANE_W;

    logic              lane_off;
    logic [LANE_W-1:0] low;
    logic [KEEP_W-1:0] upper_nd;

    always_comb begin
        lane_off  = form_is_masked(form) && mask_en && !mask_bit;
        low       = lane_off ? (zero_mode ? '0 : dst_old[LANE_W-1:0]) : prod;
        flags_out = lane_off ? '0 : flags_in;
    end

    if (VLEN > 2 * LANE_W) begin : g_wide
        assign upper_nd = {{(VLEN-2*LANE_W){1'b0}}, a_hi};
    end else begin : g_narrow
        assign upper_nd = a_hi;
    end

    always_comb begin
        if (form == FORM_DESTRUCT) dst_out = {dst_old[VLEN-1:LANE_W], low};
        else                       dst_out = {upper_nd, low};
    end

endmodule

// File: rtl/scalar_dmul_unit.sv
`timescale 1ns/1ps
module scalar_dmul_unit
    import dmul_pkg::*;
#(
    parameter int VLEN = 512
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      form,
    input  logic [127:0]    src_a,
    input  logic [63:0]     src_b,
    input  logic [VLEN-1:0] dst_old,
    input  logic            mask_en,
    input  logic            mask_bit,
    input  logic            zero_mode,
    input  logic            rc_static_en,
    input  logic            b_is_reg,
    input  logic [1:0]      rc_static,
    input  logic [1:0]      rc_csr,
    output logic            out_valid,
    output logic [VLEN-1:0] dst_new,
    output logic [4:0]      exc_flags
);

    form_e             form_t;
    rmode_e            rmode;
    logic [LANE_W-1:0] prod;
    exc_t              core_flags, lane_flags;
    logic [VLEN-1:0]   dst_d;
    ostate_e           state_q, state_d;

    assign form_t = form_e'(form);

    dmul_rsel u_rsel (
        .form         (form_t),
        .rc_static_en (rc_static_en),
        .b_is_reg     (b_is_reg),
        .rc_static    (rc_static),
        .rc_csr       (rc_csr),
        .rmode        (rmode)
    );

    dmul_core u_core (
        .opa   (src_a[LANE_W-1:0]),
        .opb   (src_b),
        .rmode (rmode),
        .res   (prod),
        .flags (core_flags)
    );

    dmul_lane_build #(.VLEN(VLEN)) u_lane (
        .form      (form_t),
        .mask_en   (mask_en),
        .mask_bit  (mask_bit),
        .zero_mode (zero_mode),
        .a_hi      (src_a[2*LANE_W-1:LANE_W]),
        .dst_old   (dst_old),
        .prod      (prod),
        .flags_in  (core_flags),
        .dst_out   (dst_d),
        .flags_out (lane_flags)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = in_valid ? ST_SHOW : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst_new   <= '0;
            exc_flags <= '0;
        end else if (in_valid) begin
            dst_new   <= dst_d;
            exc_flags <= lane_flags;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: out_valid = 1'b0;
            ST_SHOW: out_valid = 1'b1;
        endcase
    end

endmodule

// File: rtl/dmul_checker.sv
`timescale 1ns/1ps
module dmul_checker #(
    parameter int VLEN = 512
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [1:0]      form,
    input logic [127:64]   a_hi,
    input logic [VLEN-1:0] dst_old,
    input logic            mask_en,
    input logic            mask_bit,
    input logic            zero_mode,
    input logic            out_valid,
    input logic [VLEN-1:0] dst_new,
    input logic [4:0]      exc_flags
);

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R12

    AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(dst_new) && $stable(exc_flags)); // R12

    AST_DESTRUCT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && form == 2'b00 |=> dst_new[VLEN-1:64] == $past(dst_old[VLEN-1:64])); // R3

    AST_MID_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && form != 2'b00 |=> dst_new[127:64] == $past(a_hi)); // R4

    if (VLEN > 128) begin : g_top_zero
        AST_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && form != 2'b00 |=> dst_new[VLEN-1:128] == '0); // R4
    end

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && form[1] && mask_en && !mask_bit |=> exc_flags == 5'b0); // R5

    AST_MASK_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && form[1] && mask_en && !mask_bit && !zero_mode
        |=> dst_new[63:0] == $past(dst_old[63:0])); // R5

    AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && exc_flags[2] |-> exc_flags[0]); // R9

    AST_UNF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && exc_flags[1] |-> exc_flags[0]); // R10

endmodule

bind scalar_dmul_unit dmul_checker #(.VLEN(VLEN)) u_dmul_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .form      (form),
    .a_hi      (src_a[127:64]),
    .dst_old   (dst_old),
    .mask_en   (mask_en),
    .mask_bit  (mask_bit),
    .zero_mode (zero_mode),
    .out_valid (out_valid),
    .dst_new   (dst_new),
    .exc_flags (exc_flags)
);

// File: tb/test_scalar_dmul_unit.sv
`timescale 1ns/1ps
module test_scalar_dmul_unit;

    localparam int VLEN = 512;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [1:0]      form = '0;
    logic [127:0]    src_a = '0;
    logic [63:0]     src_b = '0;
    logic [VLEN-1:0] dst_old = '0;
    logic            mask_en = 1'b0, mask_bit = 1'b0, zero_mode = 1'b0;
    logic            rc_static_en = 1'b0, b_is_reg = 1'b0;
    logic [1:0]      rc_static = '0, rc_csr = '0;
    logic            out_valid;
    logic [VLEN-1:0] dst_new;
    logic [4:0]      exc_flags;

    int n_chk = 0;
    int n_bad = 0;

    scalar_dmul_unit #(.VLEN(VLEN)) i_scalar_dmul_unit (.*);

    always #4 clk = ~clk;

    function automatic logic [VLEN-1:0] rnd_vec();
        logic [VLEN-1:0] v;
        for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // Integer-rounded product for normal operands whose product stays normal. Returns {inexact, value}.
    function automatic logic [64:0] ref_mul(logic [63:0] a, logic [63:0] b, logic [1:0] rm);
        logic [52:0]  ma, mb, m;
        logic [105:0] p;
        logic [52:0]  rest;
        logic [53:0]  m2;
        logic         s, up;
        int           e;
        ma = {1'b1, a[51:0]};
        mb = {1'b1, b[51:0]};
        p  = ma * mb;
        s  = a[63] ^ b[63];
        e  = int'(a[62:52]) + int'(b[62:52]) - 1023;
        if (p[105]) begin m = p[105:53]; rest = p[52:0]; e = e + 1; end
        else begin m = p[104:52]; rest = {p[51:0], 1'b0}; end
        case (rm)
            2'b00:   up = (rest > (53'd1 << 52)) || (rest == (53'd1 << 52) && m[0]);
            2'b01:   up = (rest != 0) && s;
            2'b10:   up = (rest != 0) && !s;
            default: up = 1'b0;
        endcase
        m2 = {1'b0, m} + 54'(up);
        if (m2[53]) begin m2 = m2 >> 1; e = e + 1; end
        return {rest != 0, s, e[10:0], m2[51:0]};
    endfunction

    function automatic logic [VLEN-1:0] exp_dst(logic [1:0] f, logic men, logic mb, logic zm,
                                                 logic [127:0] a, logic [VLEN-1:0] d, logic [63:0] low);
        logic [63:0] l;
        l = low;
        if (f[1] && men && !mb) l = zm ? 64'd0 : d[63:0];
        if (f == 2'b00) return {d[VLEN-1:64], l};
        return {{(VLEN-128){1'b0}}, a[127:64], l};
    endfunction

    task automatic drive(logic [1:0] f, logic men, logic mb, logic zm, logic sen, logic breg,
                         logic [1:0] rs, logic [1:0] rc, logic [63:0] a, logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; form = f; mask_en = men; mask_bit = mb; zero_mode = zm;
        rc_static_en = sen; b_is_reg = breg; rc_static = rs; rc_csr = rc;
        src_a = {$urandom, $urandom, a}; src_b = b; dst_old = rnd_vec();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check(logic [VLEN-1:0] ed, logic [4:0] ef, string req);
        n_chk++;
        if (!out_valid || dst_new !== ed || exc_flags !== ef) begin
            n_bad++;
            $display("FAIL %s: valid=%b low=%h flags=%b hi=%h expected low=%h flags=%b hi=%h",
                     req, out_valid, dst_new[63:0], exc_flags, dst_new[127:64],
                     ed[63:0], ef, ed[127:64]);
        end
    endtask

    // Destructive form, no mask, control-register rounding.
    task automatic dir(logic [63:0] a, logic [63:0] b, logic [1:0] rc,
                       logic [63:0] er, logic [4:0] ef, string req);
        drive(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, rc, a, b);
        check(exp_dst(2'b00, 1'b0, 1'b0, 1'b0, src_a, dst_old, er), ef, req);
    endtask

    localparam logic [63:0] ONE = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] TWO = 64'h4000_0000_0000_0000;
    localparam logic [63:0] HALF = 64'h3FE0_0000_0000_0000;
    localparam logic [63:0] MAXF = 64'h7FEF_FFFF_FFFF_FFFF;
    localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [VLEN-1:0] hold;
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || dst_new !== '0 || exc_flags !== 5'b0) begin
            n_bad++;
            $display("FAIL R12 reset: valid=%b flags=%b expected valid=0 flags=00000", out_valid, exc_flags);
        end
        rst_n = 1'b1;

        // R7 infinity times zero, both orders
        dir(PINF, 64'h0, 2'b00, 64'hFFF8_0000_0000_0000, 5'b10000, "R7 inf*0");
        dir(64'h8000_0000_0000_0000, 64'hFFF0_0000_0000_0000, 2'b00, 64'hFFF8_0000_0000_0000, 5'b10000, "R7 -0*-inf");
        // R6 NaN handling
        dir(64'h7FF0_0000_0000_0001, ONE, 2'b00, 64'h7FF8_0000_0000_0001, 5'b10000, "R6 sNaN quieted");
        dir(64'h7FF8_0000_0000_0005, 64'hFFF8_0000_0000_0009, 2'b00, 64'h7FF8_0000_0000_0005, 5'b00000, "R6 first NaN wins");
        dir(ONE, 64'hFFF4_0000_0000_0003, 2'b00, 64'hFFFC_0000_0000_0003, 5'b10000, "R6 second sNaN");
        // R8 signs of zero and infinity
        dir(64'h8000_0000_0000_0000, 64'h4008_0000_0000_0000, 2'b00, 64'h8000_0000_0000_0000, 5'b00000, "R8 -0*3");
        dir(64'hFFF0_0000_0000_0000, 64'hC000_0000_0000_0000, 2'b00, PINF, 5'b00000, "R8 -inf*-2");
        // R9 overflow per mode
        dir(MAXF, TWO, 2'b00, PINF, 5'b00101, "R9 ovf nearest");
        dir(MAXF, TWO, 2'b11, MAXF, 5'b00101, "R9 ovf toward zero");
        dir(MAXF, TWO, 2'b01, MAXF, 5'b00101, "R9 ovf down positive");
        dir({1'b1, MAXF[62:0]}, TWO, 2'b01, 64'hFFF0_0000_0000_0000, 5'b00101, "R9 ovf down negative");
        dir({1'b1, MAXF[62:0]}, TWO, 2'b10, {1'b1, MAXF[62:0]}, 5'b00101, "R9 ovf up negative");
        // R10 underflow and exact subnormals
        dir(64'h0010_0000_0000_0000, HALF, 2'b00, 64'h0008_0000_0000_0000, 5'b00000, "R10 exact subnormal");
        dir(64'h0010_0000_0000_0001, HALF, 2'b00, 64'h0008_0000_0000_0000, 5'b00011, "R10 tie even");
        dir(64'h0010_0000_0000_0001, HALF, 2'b10, 64'h0008_0000_0000_0001, 5'b00011, "R10 tie up");
        // R11 denormal operand
        dir(64'h0000_0000_0000_0001, TWO, 2'b00, 64'h0000_0000_0000_0002, 5'b01000, "R11 denormal exact");
        dir(64'h0000_0000_0000_0001, HALF, 2'b00, 64'h0, 5'b01011, "R11 R10 tie to zero");
        dir(64'h0000_0000_0000_0001, 64'h7FF8_0000_0000_0000, 2'b00, 64'h7FF8_0000_0000_0000, 5'b00000, "R11 no denormal with NaN");

        // R5 masked-off lane hides overflow flags (zeroing, then merging)
        drive(2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, MAXF, TWO);
        check(exp_dst(2'b10, 1'b1, 1'b0, 1'b1, src_a, dst_old, 64'h0), 5'b00000, "R5 R4 zeroing");
        drive(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, MAXF, TWO);
        check(exp_dst(2'b11, 1'b1, 1'b0, 1'b0, src_a, dst_old, 64'h0), 5'b00000, "R5 merging");
        drive(2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, MAXF, TWO);
        check(exp_dst(2'b10, 1'b1, 1'b1, 1'b1, src_a, dst_old, PINF), 5'b00101, "R5 mask set");
        // R2 static rounding gating
        drive(2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b11, 2'b00, MAXF, TWO);
        check(exp_dst(2'b10, 1'b0, 1'b0, 1'b0, src_a, dst_old, PINF), 5'b00101, "R2 memory operand");
        drive(2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 2'b00, MAXF, TWO);
        check(exp_dst(2'b10, 1'b0, 1'b0, 1'b0, src_a, dst_old, MAXF), 5'b00101, "R2 static used");
        drive(2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 2'b00, MAXF, TWO);
        check(exp_dst(2'b01, 1'b0, 1'b0, 1'b0, src_a, dst_old, PINF), 5'b00101, "R2 R4 three-op ignores static");

        // R12 hold with no input
        hold = dst_new;
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || dst_new !== hold) begin
            n_bad++;
            $display("FAIL R12 hold: valid=%b changed=%b expected valid=0 changed=0", out_valid, dst_new !== hold);
        end

        // R1 R3 R4 R5 R13 random normal operands across forms, masks and rounding sources
        for (int k = 0; k < 400; k++) begin
            logic [63:0] a, b, er;
            logic [64:0] rr;
            logic [1:0]  f, rs, rc, rm;
            logic        men, mb, zm, sen, breg, off;
            a = {1'(($urandom)), 11'(600 + $urandom % 800), 20'($urandom), 32'($urandom)};
            b = {1'(($urandom)), 11'(600 + $urandom % 800), 20'($urandom), 32'($urandom)};
            f = 2'($urandom % 4); men = 1'($urandom); mb = 1'($urandom); zm = 1'($urandom);
            sen = 1'($urandom); breg = 1'($urandom); rs = 2'($urandom); rc = 2'($urandom);
            rm = (f[1] && sen && breg) ? rs : rc;
            rr = ref_mul(a, b, rm);
            er = (rm == 2'b00) ? $realtobits($bitstoreal(a) * $bitstoreal(b)) : rr[63:0];
            off = f[1] && men && !mb;
            drive(f, men, mb, zm, sen, breg, rs, rc, a, b);
            check(exp_dst(f, men, mb, zm, src_a, dst_old, er), off ? 5'b0 : {4'b0, rr[64]},
                  "R1 R3 R4 R5 R13 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule